// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the program counter of a small 8-bit processor and decides, every time the processor steps, where the next fetch comes from. Decode logic elsewhere presents a transfer kind together with the immediate address bits, the accumulator, a signed short offset, the byte length of the current instruction, the byte length of the instruction after it, and the outcome of a test. The sequencer turns these into the following address.

Five kinds of transfer are supported besides plain advance. A full-width jump loads the whole address. A page jump replaces the low 12 bits and keeps the page number. An accumulator-indirect jump replaces the low byte and keeps the rest. A short relative branch adds a sign-extended 6-bit offset with no page limit. A conditional skip steps over the following instruction, whatever its length, when its test fails.

The combinational next address is exposed for early fetch. The registered counter carries a registered flag that marks addresses beyond the implemented program memory, so that the fetch path can return the zero trap opcode for them.

Top module: `pcseq_core`

## Requirements
- R1: A cycle with `rst` high sets `pc_q` to 0 and `fetch_bad` to 0 on the next rising clock edge.
- R2: With `step` low, `pc_q` and `fetch_bad` keep their values. With `step` high, `pc_q` takes the value shown on `pc_next` in that cycle.
- R3: Sequential advance (`kind` = 0, and the unused codes 6 and 7) gives `pc_next = (pc_q + cur_len) mod 2^15`. `cur_len` and `next_len` carry byte counts from 1 to 3.
- R4: A long jump (`kind` = 1) gives `pc_next = imm_addr`, all 15 bits.
- R5: A page jump (`kind` = 2) gives `pc_next = {pc_q[14:12], imm_addr[11:0]}`.
- R6: An indirect jump (`kind` = 3) gives `pc_next = {pc_q[14:8], acc}`.
- R7: A relative branch (`kind` = 4) with a nonzero `rel_off` gives `pc_next = (pc_q + sign-extended rel_off) mod 2^15`. The offset runs from -32 to +31, measured from the address of the branch opcode, and may cross any 4K page.
- R8: A relative branch whose `rel_off` is 0 is not a branch encoding. It advances sequentially, as in R3.
- R9: A conditional skip (`kind` = 5) with `cond_ok` high gives `pc_q + cur_len`. With `cond_ok` low it gives `pc_q + cur_len + next_len`, mod 2^15.
- R10: `fetch_bad` is high exactly when `pc_q` is at or above `MEM_BYTES` (24576 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Update the counter this cycle |
| kind | input | 3 | Transfer kind: 0 seq, 1 long, 2 page, 3 indirect, 4 relative, 5 skip |
| imm_addr | input | 15 | Immediate address field from the instruction |
| acc | input | 8 | Accumulator value for indirect jumps |
| rel_off | input | 6 | Signed relative branch offset |
| cur_len | input | 2 | Length in bytes of the current instruction |
| next_len | input | 2 | Length in bytes of the following instruction |
| cond_ok | input | 1 | Skip test result; low means skip |
| pc_q | output | 15 | Registered program counter |
| pc_next | output | 15 | Combinational next counter value |
| fetch_bad | output | 1 | Registered flag: `pc_q` lies outside program memory |

## Verification
`pc_next` is combinational, so the bench checks it 1 ns after it drives inputs on the falling edge, in the same cycle. `pc_q` and `fetch_bad` pass through one register each, so the bench checks them after the following falling edge, one cycle after the stimulus. The bench sweeps every accumulator value and every relative offset from several base addresses, including the top-of-space wrap and a page crossing. It also covers every length and skip outcome, and addresses on both sides of the memory limit.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    XF_SEQ  = 3'd0,
    XF_LONG = 3'd1,
    XF_PAGE = 3'd2,
    XF_IND  = 3'd3,
    XF_REL  = 3'd4,
    XF_SKIP = 3'd5
  } xfer_e;
endpackage

// File: rtl/pcseq_incr.sv
// Sequential and skip advance adders.
module pcseq_incr #(
  parameter int PC_W  = 15,
  parameter int LEN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] cur_len,
  input  logic [LEN_W-1:0] next_len,
  output logic [PC_W-1:0]  seq_tgt,
  output logic [PC_W-1:0]  skip_tgt
);
  localparam int PADW = PC_W - LEN_W;

  always_comb begin
    seq_tgt  = pc + {{PADW{1'b0}}, cur_len};
    skip_tgt = seq_tgt + {{PADW{1'b0}}, next_len};
  end
endmodule

// File: rtl/pcseq_target.sv
// Jump target formation for page, indirect and relative transfers.
module pcseq_target #(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12,
  parameter int IND_W  = 8,
  parameter int REL_W  = 6
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  imm_addr,
  input  logic [IND_W-1:0] acc,
  input  logic [REL_W-1:0] rel_off,
  output logic [PC_W-1:0]  page_tgt,
  output logic [PC_W-1:0]  ind_tgt,
  output logic [PC_W-1:0]  rel_tgt,
  output logic             rel_zero
);
  localparam int EXTW = PC_W - REL_W;

  logic [PC_W-1:0] rel_ext;

  always_comb begin
    page_tgt = {pc[PC_W-1:PAGE_W], imm_addr[PAGE_W-1:0]};
    ind_tgt  = {pc[PC_W-1:IND_W], acc};
    rel_ext  = {{EXTW{rel_off[REL_W-1]}}, rel_off};
    rel_tgt  = pc + rel_ext;
    rel_zero = (rel_off == '0);
  end
endmodule

// File: rtl/pcseq_range.sv
// Program-memory bound check.
module pcseq_range #(
  parameter int PC_W      = 15,
  parameter int MEM_BYTES = 24576
) (
  input  logic [PC_W-1:0] addr,
  output logic            out_of_range
);
  localparam longint SPACE = longint'(1) << PC_W;

  generate
    if (longint'(MEM_BYTES) >= SPACE) begin : g_full
      assign out_of_range = 1'b0;
    end else begin : g_part
      localparam logic [PC_W-1:0] LIMIT = PC_W'(MEM_BYTES);
      assign out_of_range = (addr >= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/pcseq_core.sv
module pcseq_core #(
  parameter int PC_W      = 15,
  parameter int PAGE_W    = 12,
  parameter int IND_W     = 8,
  parameter int REL_W     = 6,
  parameter int LEN_W     = 2,
  parameter int MEM_BYTES = 24576
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [2:0]       kind,
  input  logic [PC_W-1:0]  imm_addr,
  input  logic [IND_W-1:0] acc,
  input  logic [REL_W-1:0] rel_off,
  input  logic [LEN_W-1:0] cur_len,
  input  logic [LEN_W-1:0] next_len,
  input  logic             cond_ok,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  pc_next,
  output logic             fetch_bad
);
  import pcseq_pkg::*;

  localparam int PADW = PC_W - LEN_W;

  logic [PC_W-1:0] seq_tgt, skip_tgt, page_tgt, ind_tgt, rel_tgt;
  logic            rel_zero;
  logic            next_bad;
  xfer_e           xk;

  pcseq_incr #(.PC_W(PC_W), .LEN_W(LEN_W)) u_incr (
    .pc(pc_q), .cur_len(cur_len), .next_len(next_len),
    .seq_tgt(seq_tgt), .skip_tgt(skip_tgt)
  );

  pcseq_target #(.PC_W(PC_W), .PAGE_W(PAGE_W), .IND_W(IND_W), .REL_W(REL_W)) u_target (
    .pc(pc_q), .imm_addr(imm_addr), .acc(acc), .rel_off(rel_off),
    .page_tgt(page_tgt), .ind_tgt(ind_tgt), .rel_tgt(rel_tgt), .rel_zero(rel_zero)
  );

  pcseq_range #(.PC_W(PC_W), .MEM_BYTES(MEM_BYTES)) u_range (
    .addr(pc_next), .out_of_range(next_bad)
  );

  always_comb begin
    xk = xfer_e'(kind);
    unique case (xk)
      XF_LONG: pc_next = imm_addr;
      XF_PAGE: pc_next = page_tgt;
      XF_IND:  pc_next = ind_tgt;
      XF_REL:  pc_next = rel_zero ? seq_tgt : rel_tgt;
      XF_SKIP: pc_next = cond_ok ? seq_tgt : skip_tgt;
      default: pc_next = seq_tgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      fetch_bad <= 1'b0;
    end else if (step) begin
      pc_q      <= pc_next;
      fetch_bad <= next_bad;
    end
  end

  // R1: reset clears counter and flag
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !fetch_bad));

  // R2: counter holds while not stepping
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc_q) && $stable(fetch_bad)));

  // R5: page jump keeps the page number
  a_r5_page_keep: assert property (@(posedge clk) disable iff (rst)
    (step && kind == 3'd2) |=>
      (pc_q[PC_W-1:PAGE_W] == $past(pc_q[PC_W-1:PAGE_W]) &&
       pc_q[PAGE_W-1:0] == $past(imm_addr[PAGE_W-1:0])));

  // R6: indirect jump takes low byte from accumulator
  a_r6_ind_keep: assert property (@(posedge clk) disable iff (rst)
    (step && kind == 3'd3) |=>
      (pc_q[IND_W-1:0] == $past(acc) &&
       pc_q[PC_W-1:IND_W] == $past(pc_q[PC_W-1:IND_W])));

  // R8: zero relative offset behaves as plain advance
  a_r8_rel_zero: assert property (@(posedge clk) disable iff (rst)
    (step && kind == 3'd4 && rel_off == '0) |=>
      (pc_q == $past(pc_q) + {{PADW{1'b0}}, $past(cur_len)}));

  // R9: failed skip test steps over the following instruction
  a_r9_skip: assert property (@(posedge clk) disable iff (rst)
    (step && kind == 3'd5 && !cond_ok) |=>
      (pc_q == $past(pc_q) + {{PADW{1'b0}}, $past(cur_len)}
                           + {{PADW{1'b0}}, $past(next_len)}));

  // R10: flag tracks the registered address against the memory limit
  a_r10_bad_flag: assert property (@(posedge clk) disable iff (rst)
    ((longint'(MEM_BYTES) < (longint'(1) << PC_W)) ?
       (fetch_bad == (longint'(pc_q) >= longint'(MEM_BYTES))) : !fetch_bad));
endmodule

// File: tb/pcseq_core_bench.sv
module pcseq_core_bench;
  localparam int CLK_NS = 10;
  localparam int MEMB   = 24576;

  logic        clk = 1'b0;
  logic        rst, step, cond_ok;
  logic [2:0]  kind;
  logic [14:0] imm_addr;
  logic [7:0]  acc;
  logic [5:0]  rel_off;
  logic [1:0]  cur_len, next_len;
  logic [14:0] pc_q, pc_next;
  logic        fetch_bad;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  pcseq_core u_pcseq_core (
    .clk(clk), .rst(rst), .step(step), .kind(kind), .imm_addr(imm_addr),
    .acc(acc), .rel_off(rel_off), .cur_len(cur_len), .next_len(next_len),
    .cond_ok(cond_ok), .pc_q(pc_q), .pc_next(pc_next), .fetch_bad(fetch_bad)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_next(input int k, input int imm, input int a,
                                     input int off, input int cl, input int nl,
                                     input bit c);
    int soff;
    soff = (off >= 32) ? off - 64 : off;
    case (k)
      1: return imm & 32'h7FFF;
      2: return (model & 32'h7000) | (imm & 32'h0FFF);
      3: return (model & 32'h7F00) | a;
      4: return (off == 0) ? ((model + cl) & 32'h7FFF) : ((model + soff) & 32'h7FFF);
      5: return c ? ((model + cl) & 32'h7FFF) : ((model + cl + nl) & 32'h7FFF);
      default: return (model + cl) & 32'h7FFF;
    endcase
  endfunction

  // Drive after falling edge, check pc_next 1 ns later, check registers after next falling edge.
  task automatic do_step(input string req, input int k, input int imm, input int a,
                         input int off, input int cl, input int nl, input bit c);
    int e;
    step = 1'b1; kind = 3'(k); imm_addr = 15'(imm); acc = 8'(a);
    rel_off = 6'(off); cur_len = 2'(cl); next_len = 2'(nl); cond_ok = c;
    e = expect_next(k, imm, a, off, cl, nl, c);
    #1;
    chk({req, " pc_next"}, int'(pc_next), e);
    @(posedge clk);
    @(negedge clk);
    model = e;
    chk({req, " pc_q"}, int'(pc_q), e);
    chk("R10 fetch_bad", int'(fetch_bad), (e >= MEMB) ? 1 : 0);
  endtask

  task automatic go_to(input int addr);
    do_step("R4", 1, addr, 0, 0, 1, 1, 1'b1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; step = 1'b0; kind = 3'd0; imm_addr = '0; acc = '0;
    rel_off = '0; cur_len = 2'd1; next_len = 2'd1; cond_ok = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset pc", int'(pc_q), 0);
    chk("R1 reset flag", int'(fetch_bad), 0);
    model = 0;

    // R3: sequential advance, all lengths, unused codes and wrap
    for (int cl = 1; cl <= 3; cl++) do_step("R3", 0, 0, 0, 0, cl, 1, 1'b1);
    do_step("R3 code6", 6, 0, 0, 0, 2, 1, 1'b1);
    do_step("R3 code7", 7, 0, 0, 0, 3, 1, 1'b1);
    go_to(32'h7FFE);
    do_step("R3 wrap", 0, 0, 0, 0, 3, 1, 1'b1);

    // R2: hold while step low, with a jump presented
    go_to(32'h6001);
    step = 1'b0; kind = 3'd1; imm_addr = 15'h0123;
    @(posedge clk); @(negedge clk);
    chk("R2 hold pc", int'(pc_q), 32'h6001);
    chk("R2 hold flag", int'(fetch_bad), 1);

    // R4 / R10: long jumps around the memory limit
    go_to(MEMB - 1);
    go_to(MEMB);
    go_to(32'h7FFF);
    go_to(0);

    // R5: page jumps from each page
    for (int p = 0; p < 8; p++) begin
      go_to(p * 4096 + 32'h0ABC);
      do_step("R5", 2, 32'h7FFF ^ (p * 273), 0, 0, 1, 1, 1'b1);
      do_step("R5", 2, 32'h0000, 0, 0, 1, 1, 1'b1);
    end

    // R6: every accumulator value
    go_to(32'h5A77);
    for (int a = 0; a < 256; a++) do_step("R6", 3, 0, a, 0, 1, 1, 1'b1);

    // R7 / R8: every offset from bases at both wrap ends and a page edge
    begin
      int bases [3] = '{32'h7FF0, 32'h0005, 32'h0FF0};
      foreach (bases[i]) begin
        for (int o = 0; o < 64; o++) begin
          go_to(bases[i]);
          do_step((o == 0) ? "R8" : "R7", 4, 0, 0, o, 2, 1, 1'b1);
        end
      end
    end

    // R9: skip with every length pair and both outcomes
    go_to(32'h1000);
    for (int cl = 1; cl <= 3; cl++)
      for (int nl = 1; nl <= 3; nl++) begin
        do_step("R9 taken", 5, 0, 0, 0, cl, nl, 1'b0);
        do_step("R9 not", 5, 0, 0, 0, cl, nl, 1'b1);
      end
    go_to(32'h7FFE);
    do_step("R9 wrap", 5, 0, 0, 0, 3, 3, 1'b0);

    // R1: reset mid-run
    go_to(32'h7000);
    step = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 rerun pc", int'(pc_q), 0);
    chk("R1 rerun flag", int'(fetch_bad), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule